// File: doc/BRIEF.md
# Tagged FIFO Latency and Data Checker

This block is a synthesizable monitor placed beside an in-order FIFO. It observes the push strobe with its input bus and the pop strobe with its output byte. It needs no access to the FIFO's internals. Every accepted push is handed the next number from an input ticket counter. The push's low byte and the cycle in which it happened go into a small tracking table, in the slot picked by the low ticket bits.

A second ticket counter names the entry that is "now being served". A pop can only complete that one entry. When equal bytes are pushed twice, one pop therefore settles at most one of them. The second push stays pending until a later pop, or until it times out.

A completing pop is judged in its own cycle. The byte must match the stored byte, and the pop must fall between the minimum and maximum latency after that entry's push. An entry still unserved when its age reaches the maximum is retired as a timeout. Every retirement advances the serving counter and produces a one-cycle pass or fail pulse together with the retired ticket number. Sticky error flags record each kind of fault until a synchronous reset.

Top module: `fifo_tag_checker`

## Requirements
- R1: On a push, only the low 8 bits of `push_bus` (bits 7:0) are stored. A completing pop fails and sets `data_err` when `pop_data` differs from that stored byte; the upper bits of `push_bus` never affect the outcome.
- R2: Age is counted in clock edges from the push edge, which is age 0. A pop at age 5 through 10 inclusive with matching data passes. A pop at age below 5 fails and sets `early_err`.
- R3: Each tracked push takes the current input ticket, and the input ticket then increments by one. The first push after reset takes ticket 0.
- R4: A pop completes only the oldest outstanding entry. With pushes at cycles 0 and 2 and a pop at cycle 4, ticket 0 is retired (early fail) and ticket 1 stays pending. A pop at cycle 8 then retires ticket 1 as a pass.
- R5: The serving ticket advances by one on every retirement, whether it passes or fails. `done_ticket` carries the retired ticket in the same cycle as its pulse, so retired tickets appear in consecutive order.
- R6: If the oldest entry reaches age 10 without a pop, it is retired in that cycle as a fail and `timeout_err` is set. At age 9 there is no retirement.
- R7: A push while DEPTH entries are outstanding (table state before that edge) sets `overflow_err`. That push is not tracked and consumes no ticket.
- R8: A pop while no entry is outstanding sets `underflow_err` and produces no pulse.
- R9: Synchronous active-high `rst` clears both ticket counters, all table entries, all error flags and both pulses. Error flags otherwise stay set once set.
- R10: `pass_pulse` and `fail_pulse` are registered, last one cycle per retirement (one edge after the deciding edge), and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Push strobe of the observed FIFO |
| push_bus | input | IN_W | Input data bus; the low byte is tracked |
| pop | input | 1 | Pop strobe of the observed FIFO |
| pop_data | input | DATA_W | Byte delivered by the observed FIFO on a pop |
| overflow_err | output | 1 | Sticky: push seen with a full tracking table |
| underflow_err | output | 1 | Sticky: pop seen with nothing outstanding |
| early_err | output | 1 | Sticky: pop came before the minimum latency |
| data_err | output | 1 | Sticky: popped byte differed from the pushed byte |
| timeout_err | output | 1 | Sticky: oldest entry reached maximum latency unserved |
| pass_pulse | output | 1 | One-cycle pulse: an entry retired cleanly |
| fail_pulse | output | 1 | One-cycle pulse: an entry retired with a fault |
| done_ticket | output | TICK_W | Ticket of the entry retired with the current pulse |

## Verification
Four properties are checked on every cycle: the two pulses never overlap, retired tickets come out in strict consecutive order, the head entry's age never passes the maximum, and error flags never drop without reset. Further properties tie an early pop, an empty-table pop and a full-table push to their flags one cycle later. Other behaviour can only be shown by the bench's scenarios. These include the shared-data case where one pop must not settle two pushes, and the exact edges of the 5-to-10 window. They also include the proof that a dropped overflow push consumed no ticket, and the agreement of every byte comparison with a reference queue under random traffic.

// File: rtl/fifo_tag_pkg.sv
package fifo_tag_pkg;
  localparam int STAMP_W = 8;
  typedef logic [STAMP_W-1:0] stamp_t;

  // cycles elapsed between a recorded stamp and the free-running time base
  function automatic stamp_t age_of(input stamp_t now_t, input stamp_t then_t);
    return stamp_t'(now_t - then_t);
  endfunction

  function automatic logic below(input stamp_t age, input int unsigned lim);
    return 32'(age) < lim;
  endfunction

  function automatic logic at_or_above(input stamp_t age, input int unsigned lim);
    return 32'(age) >= lim;
  endfunction
endpackage

// File: rtl/tick_ctr.sv
module tick_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)      value <= '0;
    else if (inc) value <= value + W'(1);
  end
endmodule

// File: rtl/tag_table.sv
module tag_table
  import fifo_tag_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  stamp_t            wr_stamp,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              wr_busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output stamp_t            rd_stamp
);
  logic [DEPTH-1:0]  slot_valid;
  logic [DATA_W-1:0] slot_data  [DEPTH];
  stamp_t            slot_stamp [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic              v_q;
    logic [DATA_W-1:0] d_q;
    stamp_t            s_q;
    logic              hit_wr, hit_clr;

    assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(i));
    assign hit_clr = clr_en && (clr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)          v_q <= 1'b0;
      else if (hit_wr)  v_q <= 1'b1;
      else if (hit_clr) v_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        d_q <= wr_data;
        s_q <= wr_stamp;
      end
    end

    assign slot_valid[i] = v_q;
    assign slot_data[i]  = d_q;
    assign slot_stamp[i] = s_q;
  end

  assign wr_busy  = slot_valid[wr_idx];
  assign rd_valid = slot_valid[rd_idx];
  assign rd_data  = slot_data[rd_idx];
  assign rd_stamp = slot_stamp[rd_idx];
endmodule

// File: rtl/retire_judge.sv
module retire_judge
  import fifo_tag_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LAT = 5,
  parameter int MAX_LAT = 10
) (
  input  logic              pop,
  input  logic [DATA_W-1:0] pop_data,
  input  logic              head_valid,
  input  stamp_t            head_age,
  input  logic [DATA_W-1:0] head_data,
  output logic              retire,
  output logic              pass,
  output logic              early,
  output logic              data_bad,
  output logic              timeout,
  output logic              underflow
);
  logic served;

  always_comb begin
    served    = pop && head_valid;
    underflow = pop && !head_valid;
    early     = served && below(head_age, MIN_LAT);
    data_bad  = served && (pop_data != head_data);
    timeout   = !pop && head_valid && at_or_above(head_age, MAX_LAT);
    retire    = served || timeout;
    pass      = served && !early && !data_bad;
  end
endmodule

// File: rtl/fifo_tag_checker.sv
module fifo_tag_checker
  import fifo_tag_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 16,
  parameter int TICK_W  = 8,
  parameter int MIN_LAT = 5,
  parameter int MAX_LAT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [IN_W-1:0]   push_bus,
  input  logic              pop,
  input  logic [DATA_W-1:0] pop_data,
  output logic              overflow_err,
  output logic              underflow_err,
  output logic              early_err,
  output logic              data_err,
  output logic              timeout_err,
  output logic              pass_pulse,
  output logic              fail_pulse,
  output logic [TICK_W-1:0] done_ticket
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [TICK_W-1:0] in_tick, out_tick;
  stamp_t            now_t, head_stamp, head_age;
  logic [DATA_W-1:0] head_data;
  logic              head_valid, slot_busy, push_ok, ovf_ev;
  logic              retire_ev, pass_ev, early_ev, data_ev, tout_ev, udf_ev;
  logic              unused_hi;

  assign unused_hi = ^push_bus[IN_W-1:DATA_W];

  // acceptance uses table state before the edge
  assign push_ok = push && !slot_busy;
  assign ovf_ev  = push && slot_busy;

  tick_ctr #(.W(TICK_W)) u_in_tick (
    .clk(clk), .rst(rst), .inc(push_ok), .value(in_tick));

  tick_ctr #(.W(TICK_W)) u_out_tick (
    .clk(clk), .rst(rst), .inc(retire_ev), .value(out_tick));

  tick_ctr #(.W(STAMP_W)) u_time (
    .clk(clk), .rst(rst), .inc(1'b1), .value(now_t));

  tag_table #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_table (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (push_ok),
    .wr_idx   (in_tick[IDX_W-1:0]),
    .wr_data  (push_bus[DATA_W-1:0]),
    .wr_stamp (now_t),
    .clr_en   (retire_ev),
    .clr_idx  (out_tick[IDX_W-1:0]),
    .rd_idx   (out_tick[IDX_W-1:0]),
    .wr_busy  (slot_busy),
    .rd_valid (head_valid),
    .rd_data  (head_data),
    .rd_stamp (head_stamp)
  );

  assign head_age = age_of(now_t, head_stamp);

  retire_judge #(.DATA_W(DATA_W), .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT)) u_judge (
    .pop        (pop),
    .pop_data   (pop_data),
    .head_valid (head_valid),
    .head_age   (head_age),
    .head_data  (head_data),
    .retire     (retire_ev),
    .pass       (pass_ev),
    .early      (early_ev),
    .data_bad   (data_ev),
    .timeout    (tout_ev),
    .underflow  (udf_ev)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow_err  <= 1'b0;
      underflow_err <= 1'b0;
      early_err     <= 1'b0;
      data_err      <= 1'b0;
      timeout_err   <= 1'b0;
      pass_pulse    <= 1'b0;
      fail_pulse    <= 1'b0;
      done_ticket   <= '0;
    end else begin
      overflow_err  <= overflow_err  | ovf_ev;
      underflow_err <= underflow_err | udf_ev;
      early_err     <= early_err     | early_ev;
      data_err      <= data_err      | data_ev;
      timeout_err   <= timeout_err   | tout_ev;
      pass_pulse    <= pass_ev;
      fail_pulse    <= retire_ev && !pass_ev;
      if (retire_ev) done_ticket <= out_tick;
    end
  end
endmodule

// File: rtl/fifo_tag_checker_sva.sv
module fifo_tag_checker_sva
  import fifo_tag_pkg::*;
#(
  parameter int TICK_W  = 8,
  parameter int MIN_LAT = 5,
  parameter int MAX_LAT = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              push,
  input logic              pop,
  input logic              push_ok,
  input logic              head_valid,
  input stamp_t            head_age,
  input logic [TICK_W-1:0] in_tick,
  input logic              overflow_err,
  input logic              underflow_err,
  input logic              early_err,
  input logic              data_err,
  input logic              timeout_err,
  input logic              pass_pulse,
  input logic              fail_pulse,
  input logic [TICK_W-1:0] done_ticket
);
  logic [TICK_W-1:0] seen_cnt;
  logic [4:0]        errs;

  assign errs = {overflow_err, underflow_err, early_err, data_err, timeout_err};

  always_ff @(posedge clk) begin
    if (rst)                          seen_cnt <= '0;
    else if (pass_pulse || fail_pulse) seen_cnt <= seen_cnt + TICK_W'(1);
  end

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass_pulse && fail_pulse));

  // R5
  ticket_order_chk: assert property (@(posedge clk) disable iff (rst)
    (pass_pulse || fail_pulse) |-> done_ticket == seen_cnt);

  // R6
  head_age_chk: assert property (@(posedge clk) disable iff (rst)
    head_valid |-> 32'(head_age) <= MAX_LAT);

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (|errs) |=> ((errs & $past(errs)) == $past(errs)));

  // R2
  early_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && head_valid && 32'(head_age) < MIN_LAT) |=> (fail_pulse && early_err));

  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !head_valid) |=> (underflow_err && !pass_pulse && !fail_pulse));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !push_ok) |=> (overflow_err && in_tick == $past(in_tick)));

  // R3
  ticket_take_chk: assert property (@(posedge clk) disable iff (rst)
    push_ok |=> in_tick == $past(in_tick) + TICK_W'(1));
endmodule

bind fifo_tag_checker fifo_tag_checker_sva #(
  .TICK_W(TICK_W), .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT)
) u_sva (
  .clk(clk), .rst(rst), .push(push), .pop(pop), .push_ok(push_ok),
  .head_valid(head_valid), .head_age(head_age), .in_tick(in_tick),
  .overflow_err(overflow_err), .underflow_err(underflow_err),
  .early_err(early_err), .data_err(data_err), .timeout_err(timeout_err),
  .pass_pulse(pass_pulse), .fail_pulse(fail_pulse), .done_ticket(done_ticket)
);

// File: tb/fifo_tag_checker_test.sv
module fifo_tag_checker_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH_T    = 8;
  localparam int MIN_T      = 5;
  localparam int MAX_T      = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push = 1'b0, pop = 1'b0;
  logic [15:0] push_bus = '0;
  logic [7:0]  pop_data = '0;
  logic        overflow_err, underflow_err, early_err, data_err, timeout_err;
  logic        pass_pulse, fail_pulse;
  logic [7:0]  done_ticket;

  int total = 0, bad = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] m_data[$];
  int         m_time[$];
  int         m_tick[$];
  int         cyc, in_t;
  bit         e_ovf, e_udf, e_early, e_data, e_tout, e_pass, e_fail;
  int         e_tick;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_tag_checker #(.DEPTH(DEPTH_T), .MIN_LAT(MIN_T), .MAX_LAT(MAX_T)) uut (
    .clk(clk), .rst(rst), .push(push), .push_bus(push_bus), .pop(pop),
    .pop_data(pop_data), .overflow_err(overflow_err), .underflow_err(underflow_err),
    .early_err(early_err), .data_err(data_err), .timeout_err(timeout_err),
    .pass_pulse(pass_pulse), .fail_pulse(fail_pulse), .done_ticket(done_ticket));

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got=%0d exp=%0d (t=%0t)", req, what, got, exp, $time);
    end
  endtask

  function automatic bit in_window(input int age);
    return age >= MIN_T && age <= MAX_T;
  endfunction

  task automatic model_clear();
    m_data.delete(); m_time.delete(); m_tick.delete();
    cyc = 0; in_t = 0;
    {e_ovf, e_udf, e_early, e_data, e_tout, e_pass, e_fail} = '0;
    e_tick = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; push = 0; pop = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  // one clock of stimulus; the model predicts, outputs are compared after the edge
  task automatic step(input bit p, input logic [15:0] pb, input bit q, input logic [7:0] qd);
    bit full;
    int age;
    push = p; push_bus = pb; pop = q; pop_data = qd;
    full = (m_data.size() == DEPTH_T);
    e_pass = 0; e_fail = 0;
    if (q) begin
      if (m_data.size() == 0) e_udf = 1;
      else begin
        age = cyc - m_time[0];
        if (!in_window(age)) e_early = 1;
        if (m_data[0] != qd) e_data = 1;
        e_pass = in_window(age) && (m_data[0] == qd);
        e_fail = !e_pass;
        e_tick = m_tick[0] & 255;
        void'(m_data.pop_front()); void'(m_time.pop_front()); void'(m_tick.pop_front());
      end
    end else if (m_data.size() > 0 && (cyc - m_time[0]) >= MAX_T) begin
      e_fail = 1; e_tout = 1; e_tick = m_tick[0] & 255;
      void'(m_data.pop_front()); void'(m_time.pop_front()); void'(m_tick.pop_front());
    end
    if (p) begin
      if (full) e_ovf = 1;
      else begin
        m_data.push_back(pb[7:0]); m_time.push_back(cyc); m_tick.push_back(in_t);
        in_t++;
      end
    end
    cyc++;
    @(posedge clk);
    @(negedge clk);
    push = 0; pop = 0;
    chk("R10", "pass_pulse", int'(pass_pulse), int'(e_pass));
    chk("R10", "fail_pulse", int'(fail_pulse), int'(e_fail));
    if (e_pass || e_fail) chk("R5", "done_ticket", int'(done_ticket), e_tick);
    chk("R7", "overflow_err", int'(overflow_err), int'(e_ovf));
    chk("R8", "underflow_err", int'(underflow_err), int'(e_udf));
    chk("R2", "early_err", int'(early_err), int'(e_early));
    chk("R1", "data_err", int'(data_err), int'(e_data));
    chk("R6", "timeout_err", int'(timeout_err), int'(e_tout));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 16'h0, 0, 8'h0);
  endtask

  task automatic all_clear(input string req);
    chk(req, "flags after reset",
        int'({overflow_err, underflow_err, early_err, data_err, timeout_err}), 0);
    chk(req, "pulses after reset", int'({pass_pulse, fail_pulse}), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_clear();
    do_reset();
    all_clear("R9");

    // R1: upper bus bits ignored, low byte compared
    step(1, 16'hAB5C, 0, 0); idle(4);
    step(0, 0, 1, 8'h5C);
    chk("R1", "low byte pass", int'(pass_pulse), 1);
    step(1, 16'h3412, 0, 0); idle(4);
    step(0, 0, 1, 8'h34);
    chk("R1", "byte mismatch flag", int'(data_err), 1);

    // R2: window edges
    do_reset();
    step(1, 16'h0011, 0, 0); idle(9);
    step(0, 0, 1, 8'h11);
    chk("R2", "pass at age 10", int'(pass_pulse), 1);
    step(1, 16'h0022, 0, 0); idle(3);
    step(0, 0, 1, 8'h22);
    chk("R2", "early at age 4", int'(early_err && fail_pulse), 1);

    // R8: pop with nothing outstanding
    step(0, 0, 1, 8'h00);
    chk("R8", "empty pop", int'(underflow_err), 1);

    // R4: pushes at 0 and 2 with equal data, pop at 4
    do_reset();
    step(1, 16'h0077, 0, 0); idle(1);
    step(1, 16'h0077, 0, 0); idle(1);
    step(0, 0, 1, 8'h77);
    chk("R4", "first push charged", int'(fail_pulse && done_ticket == 8'd0), 1);
    idle(3);
    step(0, 0, 1, 8'h77);
    chk("R4", "second push still pending", int'(pass_pulse && done_ticket == 8'd1), 1);

    // R6: timeout exactly at age 10
    do_reset();
    step(1, 16'h0099, 0, 0); idle(9);
    chk("R6", "no retire at age 9", int'(fail_pulse), 0);
    idle(1);
    chk("R6", "timeout at age 10", int'(fail_pulse && timeout_err), 1);

    // R7 and R3: fill the table, dropped push takes no ticket
    do_reset();
    for (int k = 0; k < DEPTH_T; k++) step(1, 16'(k + 1), 0, 0);
    step(1, 16'h00EE, 0, 0);
    chk("R7", "overflow on full", int'(overflow_err), 1);
    for (int k = 0; k < DEPTH_T; k++) begin
      step(0, 0, 1, 8'(k + 1));
      chk("R3", "sequential tickets", int'(pass_pulse && done_ticket == 8'(k)), 1);
    end
    step(1, 16'h0042, 0, 0); idle(4);
    step(0, 0, 1, 8'h42);
    chk("R7", "dropped push used no ticket", int'(done_ticket), DEPTH_T);

    // random traffic with repeated data values
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      bit p, q;
      logic [15:0] pb;
      logic [7:0] qd;
      p  = ($urandom % 100) < 40;
      pb = 16'($urandom);
      pb[7:0] = 8'($urandom % 4);
      q  = ($urandom % 100) < 35;
      if (m_data.size() > 0 && ($urandom % 100) < 85) qd = m_data[0];
      else qd = 8'($urandom % 4);
      step(p, pb, q, qd);
    end

    // R9: reset clears sticky state
    do_reset();
    all_clear("R9");
    idle(2);
    all_clear("R9");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule